// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit with Clock Stretching

This block is the hardware half of a two-wire (I2C-style) slave whose protocol decisions are made by firmware. It watches the open-drain SDA and SCL lines and shifts received bits into an 8-bit register. It drives SDA low from that register when it transmits. It counts SCL edges, detects start and stop conditions, and stretches SCL so that firmware has time to react. Address matching, acknowledge choice and byte handling all live in firmware.

Both bus lines pass through a synchronizer into the system clock domain. A start condition sets a start flag. Once the master then pulls SCL low, the unit keeps SCL low until firmware clears that flag. The 4-bit counter advances on every SCL edge, so sixteen edges make one byte. When it wraps from 15 to 0 it sets an overflow flag, which also holds SCL low until firmware clears it. For an acknowledge bit, firmware presets the counter to 14 so that it wraps after one bit.

Firmware reaches the unit through single-cycle strobes (load shift register, preset counter, write-one-to-clear flags) and through plain level inputs and outputs. There is no data stream with back-pressure: each strobe takes effect at the clock edge that samples it.

Top module: `twi_shift_unit`

## Requirements
- R1: SDA falling while SCL is high and steady sets `start_flag`. SDA rising while SCL is high and steady sets `stop_flag`.
- R2: While `start_flag` is set, the first synchronized SCL falling edge asserts `scl_pull_low`. It stays asserted until `start_flag` is cleared. Before that falling edge, a start alone does not pull SCL.
- R3: On each synchronized SCL rising edge the shift register moves one place toward bit 7 and takes the synchronized SDA level into bit 0.
- R4: `cnt_value` increments on every synchronized SCL edge, rising and falling, and wraps from 15 to 0. The wrap sets `ovf_flag`.
- R5: `scl_pull_low` is asserted whenever `ovf_flag` is set. It is released only when neither the overflow flag nor the start hold remains. Clearing one source leaves the other holding.
- R6: After a preset of 14, exactly one SCL bit (a rise and then a fall) sets `ovf_flag`, and the counter reads 0.
- R7: `sda_pull_low` is high only when `sda_oe` is 1 and the drive bit is 0. The drive bit takes shift-register bit 7 on each SCL falling edge, and takes bit 7 of the loaded value on a load. It does not change while SCL is high.
- R8: `flag_clr` is write-one-to-clear, one bit per flag: bit 0 clears start, bit 1 clears overflow, bit 2 clears stop. When a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` = (`start_flag` AND `start_ie`) OR (`ovf_flag` AND `ovf_ie`). The stop flag never raises `irq`.
- R10: A firmware load of the shift register or the counter takes priority over an SCL edge in the same cycle.
- R11: A stop condition does not stretch SCL.
- R12: After reset all flags, `cnt_value`, `sr_data`, `irq` and both pull-low outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| sda_pull_low | output | 1 | Pull SDA low when 1 |
| scl_pull_low | output | 1 | Pull SCL low (stretch) when 1 |
| sda_oe | input | 1 | Enables the SDA driver |
| sr_load | input | 1 | Strobe: load shift register |
| sr_load_val | input | 8 | Value for shift register load |
| sr_data | output | 8 | Shift register contents |
| cnt_load | input | 1 | Strobe: preset edge counter |
| cnt_load_val | input | 4 | Counter preset value |
| cnt_value | output | 4 | Edge counter contents |
| flag_clr | input | 3 | Write-one-to-clear: bit0 start, bit1 overflow, bit2 stop |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Counter wrapped |
| stop_flag | output | 1 | Stop condition seen |
| start_ie | input | 1 | Interrupt enable for start flag |
| ovf_ie | input | 1 | Interrupt enable for overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. A firmware flag clear can meet a fresh flag set, and a firmware load can meet an SCL edge. The bench changes the bus line exactly three clock edges before the strobe's sampling edge, which is the synchronizer and edge-detector latency, so that both events land on one edge. It then judges the result at the ports: `start_flag` must stay set, and `sr_data` and `cnt_value` must show the loaded values rather than the shifted or incremented ones.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int FLAG_W   = 3;
  localparam int FL_START = 0;
  localparam int FL_OVF   = 1;
  localparam int FL_STOP  = 2;

  typedef struct packed {
    logic sda;       // synchronized SDA level
    logic scl_rise;  // synchronized SCL rising edge
    logic scl_fall;  // synchronized SCL falling edge
    logic start_ev;  // SDA fell with SCL high
    logic stop_ev;   // SDA rose with SCL high
  } bus_ev_t;
endpackage

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sda_in,
  input  logic    scl_in,
  output bus_ev_t ev
);
  localparam int LINES = 2;  // bit 0 SDA, bit 1 SCL

  logic [SYNC_STAGES-1:0][LINES-1:0] stg;
  logic [LINES-1:0] now_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '1;
      prev_q <= '1;
    end else begin
      stg[0] <= {scl_in, sda_in};
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= now_q;
    end
  end

  assign now_q = stg[SYNC_STAGES-1];

  logic scl_steady_hi;
  assign scl_steady_hi = now_q[1] & prev_q[1];

  always_comb begin
    ev.sda      = now_q[0];
    ev.scl_rise = now_q[1] & ~prev_q[1];
    ev.scl_fall = ~now_q[1] & prev_q[1];
    ev.start_ev = ~now_q[0] & prev_q[0] & scl_steady_hi;
    ev.stop_ev  = now_q[0] & ~prev_q[0] & scl_steady_hi;
  end

  // R1: a start and a stop never show up together
  assert_cond_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev.start_ev && ev.stop_ev));
endmodule

// File: rtl/twi_edge_counter.sv
module twi_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap = step & ~load & (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count + 1'b1;
  end

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && step && !load) |=> (count == '0));
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/twi_shift_reg.sv
module twi_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              launch,
  input  logic              sda_bit,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] data,
  output logic              drive_bit
);
  localparam int MSB = DATA_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (load)   data <= load_val;
    else if (sample) data <= {data[MSB-1:0], sda_bit};
  end

  // Drive bit changes only while SCL is low, so SDA never moves with SCL high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drive_bit <= 1'b1;
    else if (load)   drive_bit <= load_val[MSB];
    else if (launch) drive_bit <= data[MSB];
  end

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !load) |=> (data[0] == $past(sda_bit)) &&
                         (data[MSB:1] == $past(data[MSB-1:0])));
  assert_drive_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !launch) |=> $stable(drive_bit));
endmodule

// File: rtl/twi_hold_ctrl.sv
module twi_hold_ctrl
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              wrap,
  input  logic              scl_fall,
  input  logic [FLAG_W-1:0] clr,
  output logic [FLAG_W-1:0] flags,
  output logic              scl_pull_low
);
  logic [FLAG_W-1:0] set_vec, flags_nxt;
  logic start_hold;

  always_comb begin
    set_vec           = '0;
    set_vec[FL_START] = start_ev;
    set_vec[FL_OVF]   = wrap;
    set_vec[FL_STOP]  = stop_ev;
  end

  // set wins over a same-cycle clear
  assign flags_nxt = set_vec | (flags & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      start_hold <= 1'b0;
    end else begin
      flags      <= flags_nxt;
      start_hold <= flags_nxt[FL_START] & (start_hold | (scl_fall & flags[FL_START]));
    end
  end

  assign scl_pull_low = start_hold | flags[FL_OVF];

  assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_START] && !clr[FL_START]) |=> flags[FL_START]);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FL_OVF]);
  assert_hold_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_START] && scl_fall && !clr[FL_START]) |=> scl_pull_low);
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[FL_START] && !flags[FL_OVF]) |-> !scl_pull_low);
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit
  import twi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_pull_low,
  output logic              scl_pull_low,
  input  logic              sda_oe,
  input  logic              sr_load,
  input  logic [DATA_W-1:0] sr_load_val,
  output logic [DATA_W-1:0] sr_data,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_load_val,
  output logic [CNT_W-1:0]  cnt_value,
  input  logic [FLAG_W-1:0] flag_clr,
  output logic              start_flag,
  output logic              ovf_flag,
  output logic              stop_flag,
  input  logic              start_ie,
  input  logic              ovf_ie,
  output logic              irq
);
  bus_ev_t ev;
  logic cnt_wrap, drive_bit;
  logic [FLAG_W-1:0] flags;

  twi_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in), .ev(ev)
  );

  twi_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(ev.scl_rise | ev.scl_fall),
    .load(cnt_load), .load_val(cnt_load_val), .count(cnt_value), .wrap(cnt_wrap)
  );

  twi_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .sample(ev.scl_rise), .launch(ev.scl_fall),
    .sda_bit(ev.sda), .load(sr_load), .load_val(sr_load_val),
    .data(sr_data), .drive_bit(drive_bit)
  );

  twi_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_n), .start_ev(ev.start_ev), .stop_ev(ev.stop_ev),
    .wrap(cnt_wrap), .scl_fall(ev.scl_fall), .clr(flag_clr),
    .flags(flags), .scl_pull_low(scl_pull_low)
  );

  assign start_flag   = flags[FL_START];
  assign ovf_flag     = flags[FL_OVF];
  assign stop_flag    = flags[FL_STOP];
  assign sda_pull_low = sda_oe & ~drive_bit;
  assign irq          = (start_flag & start_ie) | (ovf_flag & ovf_ie);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_flag && !ovf_flag) |-> !irq);
  assert_stop_no_stretch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && !start_flag && !ovf_flag) |-> !scl_pull_low);
endmodule

// File: tb/twi_shift_unit_test.sv
module twi_shift_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic rst_n = 1'b0;
  logic master_sda = 1'b1, master_scl = 1'b1;
  logic sda_oe = 1'b0, sr_load = 1'b0, cnt_load = 1'b0;
  logic [7:0] sr_load_val = '0;
  logic [3:0] cnt_load_val = '0;
  logic [2:0] flag_clr = '0;
  logic start_ie = 1'b0, ovf_ie = 1'b0;
  logic sda_pull_low, scl_pull_low, start_flag, ovf_flag, stop_flag, irq;
  logic [7:0] sr_data;
  logic [3:0] cnt_value;
  logic sda_line, scl_line;

  assign sda_line = master_sda & ~sda_pull_low;
  assign scl_line = master_scl & ~scl_pull_low;

  twi_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_line), .scl_in(scl_line),
    .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low), .sda_oe(sda_oe),
    .sr_load(sr_load), .sr_load_val(sr_load_val), .sr_data(sr_data),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cnt_value(cnt_value),
    .flag_clr(flag_clr), .start_flag(start_flag), .ovf_flag(ovf_flag),
    .stop_flag(stop_flag), .start_ie(start_ie), .ovf_ie(ovf_ie), .irq(irq)
  );

  typedef struct { int kind; int req; logic [7:0] exp; } item_t;
  item_t sb[$];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [7:0] observe(int kind);
    case (kind)
      0: return {7'd0, start_flag};
      1: return {7'd0, stop_flag};
      2: return {7'd0, ovf_flag};
      3: return {7'd0, scl_pull_low};
      4: return {7'd0, sda_pull_low};
      5: return {7'd0, irq};
      6: return sr_data;
      default: return {4'd0, cnt_value};
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = sb.pop_front();
      got = observe(it.kind);
      n_checks++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL R%0d: output %0d actual %h expected %h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_out(int kind, logic [7:0] exp, int req);
    item_t it;
    it.kind = kind; it.req = req; it.exp = exp;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic bus_set(logic d, logic c);
    master_sda = d; master_scl = c;
    tick(6);
  endtask

  task automatic clr_pulse(logic [2:0] bits);
    flag_clr = bits; tick(1); flag_clr = '0; tick(2);
  endtask

  task automatic sr_pulse(logic [7:0] v);
    sr_load_val = v; sr_load = 1'b1; tick(1); sr_load = 1'b0; tick(2);
  endtask

  task automatic cnt_pulse(logic [3:0] v);
    cnt_load_val = v; cnt_load = 1'b1; tick(1); cnt_load = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  localparam logic [7:0] RX_BYTE = 8'hA6;
  localparam logic [7:0] TX_BYTE = 8'h5A;

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    // R12 reset state
    expect_out(0, 0, 12); expect_out(1, 0, 12); expect_out(2, 0, 12);
    expect_out(3, 0, 12); expect_out(4, 0, 12); expect_out(5, 0, 12);
    expect_out(6, 0, 12); expect_out(7, 0, 12);

    start_ie = 1'b1; ovf_ie = 1'b1;
    bus_set(0, 1);                       // start
    expect_out(0, 1, 1);                 // R1
    expect_out(5, 1, 9);                 // R9
    expect_out(3, 0, 2);                 // R2 no hold before SCL falls
    bus_set(0, 0);
    expect_out(3, 1, 2);                 // R2 hold after fall
    expect_out(7, 1, 4);                 // R4 fall counted
    cnt_pulse(4'd0);
    expect_out(3, 1, 2);                 // R2 still held
    clr_pulse(3'b001);
    expect_out(0, 0, 8);                 // R8
    expect_out(3, 0, 2);                 // R2 released
    expect_out(5, 0, 9);                 // R9

    // receive one byte, MSB first
    for (int i = 7; i >= 0; i--) begin
      bus_set(RX_BYTE[i], 0);
      bus_set(RX_BYTE[i], 1);
      bus_set(RX_BYTE[i], 0);
      if (i == 5) expect_out(7, 4'd6, 4);  // R4 both edges counted
    end
    expect_out(2, 1, 4);                 // R4 wrap sets overflow
    expect_out(7, 0, 4);                 // R4
    expect_out(6, RX_BYTE, 3);           // R3
    expect_out(3, 1, 5);                 // R5
    expect_out(5, 1, 9);                 // R9

    // acknowledge phase
    clr_pulse(3'b001);
    expect_out(3, 1, 5);                 // R5 other source still holds
    sr_pulse(8'h00); sda_oe = 1'b1; tick(1);
    expect_out(4, 1, 7);                 // R7 load sets drive bit
    cnt_pulse(4'd14);
    clr_pulse(3'b010);
    expect_out(2, 0, 8);                 // R8
    expect_out(3, 0, 5);                 // R5 released
    master_sda = 1'b1;
    bus_set(1, 1);
    expect_out(2, 0, 6);                 // R6 not yet
    bus_set(1, 0);
    expect_out(2, 1, 6);                 // R6
    expect_out(7, 0, 6);                 // R6

    // transmit one byte
    sr_pulse(TX_BYTE);
    cnt_pulse(4'd0);
    clr_pulse(3'b010);
    for (int i = 7; i >= 0; i--) begin
      bus_set(1, 1);
      expect_out(4, {7'd0, ~TX_BYTE[i]}, 7);  // R7 bit held through SCL high
      bus_set(1, 0);
    end
    expect_out(2, 1, 4);                 // R4
    expect_out(6, TX_BYTE, 3);           // R3 echoed line
    sda_oe = 1'b0; tick(1);
    expect_out(4, 0, 7);                 // R7 disabled driver

    // stop
    clr_pulse(3'b010);
    bus_set(0, 0); bus_set(0, 1); bus_set(1, 1);
    expect_out(1, 1, 1);                 // R1
    expect_out(3, 0, 11);                // R11
    expect_out(0, 0, 1);

    // same-cycle set and clear of start flag
    bus_set(0, 1);
    bus_set(1, 1);
    master_sda = 1'b0;                   // P0
    tick(2);                             // P1, P2
    flag_clr = 3'b001;
    tick(1);                             // P3: set and clear together
    flag_clr = '0; tick(2);
    expect_out(0, 1, 8);                 // R8 set wins
    clr_pulse(3'b001);
    expect_out(0, 0, 8);                 // R8
    bus_set(1, 1);
    clr_pulse(3'b100);
    expect_out(1, 0, 8);                 // R8 stop cleared

    // same-cycle load and SCL edge
    bus_set(1, 0);
    master_scl = 1'b1;                   // P0
    tick(2);
    sr_load_val = 8'h3C; sr_load = 1'b1;
    cnt_load_val = 4'd5; cnt_load = 1'b1;
    tick(1);
    sr_load = 1'b0; cnt_load = 1'b0; tick(2);
    expect_out(6, 8'h3C, 10);            // R10
    expect_out(7, 4'd5, 10);             // R10
    bus_set(1, 0);
    expect_out(7, 4'd6, 4);              // R4

    // interrupt gating
    cnt_pulse(4'd15);
    ovf_ie = 1'b0;
    bus_set(1, 1);
    expect_out(2, 1, 4);                 // R4
    expect_out(3, 1, 5);                 // R5
    expect_out(5, 0, 9);                 // R9 masked
    ovf_ie = 1'b1; tick(1);
    expect_out(5, 1, 9);                 // R9

    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule